// File: doc/BRIEF.md
# Programmable Product-Term Address Decoder

This block turns the upper address lines, page bits, bus strobes and a few general-purpose inputs of a microcontroller bus into chip-select lines. Every output is an OR of a fixed number of product terms. Each term is an AND over a 20-bit literal vector. A care mask and a value word, both held in configuration registers, program each term. Output groups get different term budgets: eight memory-bank selects, one SRAM select and one I/O select use one term each; the first external group of four uses four terms per output; the second group of four uses two; the third group of three uses one.

The configuration is loaded through a synchronous address/data/write-enable port. The decode path from the bus inputs to the selects is purely combinational. A shared pin either serves as the top address literal or, in chip-select-input mode, forces the decoder into a quiet power-down state. Reset deselects every output but is never a term literal.

A mode controller has two registered states: HOLD, entered on reset, and RUN, reached on the first clock edge after reset ends (the HOLD-to-RUN transition). While in RUN, the live mode is DECODE, or SLEEP whenever chip-select-input mode is on and the shared pin is high. The DECODE-to-SLEEP and SLEEP-to-DECODE transitions follow the pin with no clock delay.

Top module: `pt_addr_decoder`

## Requirements
- R1: The literal vector is bit 0–7 `addr_hi`, bit 8 `a19_csi`, bits 9–12 `page`, bit 13 `rd`, bit 14 `wr`, bit 15 `ale`, bits 16–19 `aux`. A valid term is true when every bit set in its care mask matches the same bit of its value word.
- R2: A term whose enable bit is 0 is false for every input. A term that is enabled with an all-zero care mask is always true.
- R3: Term slots map to outputs in index order. Slots 0–7 drive `bank_sel[0..7]`, slot 8 drives `sram_sel`, slot 9 drives `io_sel`, slots 10+4k..13+4k drive `xcs_a[k]`, slots 26+2k..27+2k drive `xcs_b[k]`, and slot 34+k drives `xcs_c[k]`. Each output is the OR of its slots.
- R4: A write at `cfg_addr` = 4·slot + f takes effect from the next rising edge. Field f=0 loads the care mask, f=1 loads the value word, and f=2 loads the enable from `cfg_wdata[0]`. Field 3 and addresses above 148 change nothing. Term writes are dropped while `rst_n` is low.
- R5: Address 148 bit 0 selects chip-select-input mode (1) or address mode (0). It is cleared by reset, and a write to it while `rst_n` is low is dropped.
- R6: In chip-select-input mode with `a19_csi` high, all selects are 0 and `pwr_down` is 1 in the same cycle. With the pin low, decoding proceeds normally.
- R7: In address mode, `a19_csi` acts only as literal bit 8 and `pwr_down` stays 0.
- R8: While `rst_n` is low, all selects and `pwr_down` are 0. They stay 0 after release until the first rising clock edge. Term contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes and the mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 20 | Configuration write data |
| addr_hi | input | 8 | Upper address lines |
| a19_csi | input | 1 | Shared top-address / chip-select-input pin |
| page | input | 4 | Page number |
| rd | input | 1 | Read or enable strobe |
| wr | input | 1 | Write strobe or read/write select |
| ale | input | 1 | Address latch enable |
| aux | input | 4 | General-purpose auxiliary inputs |
| bank_sel | output | 8 | Internal memory-bank selects |
| sram_sel | output | 1 | Internal SRAM select |
| io_sel | output | 1 | Internal I/O-port select |
| xcs_a | output | 4 | External selects, four terms each |
| xcs_b | output | 4 | External selects, two terms each |
| xcs_c | output | 3 | External selects, one term each |
| pwr_down | output | 1 | High while the decoder is in power-down |

## Verification
The only internal state is the term store, the mode bit and the HOLD/RUN register. A corrupted care, value or enable bit appears at once as a wrong select for the input patterns that reach that term. The bench therefore walks patterns that hit each configured slot and also avoid it. A wrong mode bit shows in the same cycle as `pwr_down` or as selects that fail to drop while the shared pin is high. A stuck HOLD state keeps every select low after the first edge that follows reset release.

// File: rtl/pt_dec_pkg.sv
package pt_dec_pkg;
    localparam int FLD_CARE  = 0;
    localparam int FLD_VALUE = 1;
    localparam int FLD_EN    = 2;

    typedef enum logic {
        ST_HOLD,
        ST_RUN
    } run_state_e;

    typedef enum logic [1:0] {
        DM_RESET,
        DM_DECODE,
        DM_SLEEP
    } dec_mode_e;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
    import pt_dec_pkg::*;
#(
    parameter int IN_W    = 20,
    parameter int N_TERMS = 37,
    parameter int AW      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [IN_W-1:0]                wdata,
    output logic [N_TERMS-1:0][IN_W-1:0]   care,
    output logic [N_TERMS-1:0][IN_W-1:0]   value,
    output logic [N_TERMS-1:0]             valid,
    output logic                           csi_mode
);
    localparam logic [AW-1:0] CTRL_A = AW'(N_TERMS * 4);

    logic take;
    assign take = we & rst_n;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_slot
        localparam logic [AW-1:0] A_CARE = AW'(t * 4 + FLD_CARE);
        localparam logic [AW-1:0] A_VAL  = AW'(t * 4 + FLD_VALUE);
        localparam logic [AW-1:0] A_EN   = AW'(t * 4 + FLD_EN);
        logic [IN_W-1:0] care_r;
        logic [IN_W-1:0] val_r;
        logic            en_r;

        always_ff @(posedge clk) begin
            if (take) begin
                if (addr == A_CARE) care_r <= wdata;
                if (addr == A_VAL)  val_r  <= wdata;
                if (addr == A_EN)   en_r   <= wdata[0];
            end
        end

        assign care[t]  = care_r;
        assign value[t] = val_r;
        assign valid[t] = en_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csi_mode <= 1'b0;
        end else if (we && addr == CTRL_A) begin
            csi_mode <= wdata[0];
        end
    end
endmodule

// File: rtl/pt_term_eval.sv
module pt_term_eval #(
    parameter int IN_W    = 20,
    parameter int N_TERMS = 37
) (
    input  logic [IN_W-1:0]                in_vec,
    input  logic [N_TERMS-1:0][IN_W-1:0]   care,
    input  logic [N_TERMS-1:0][IN_W-1:0]   value,
    input  logic [N_TERMS-1:0]             valid,
    output logic [N_TERMS-1:0]             hit
);
    for (genvar t = 0; t < N_TERMS; t++) begin : g_and
        assign hit[t] = valid[t] & ~|((in_vec ^ value[t]) & care[t]);
    end
endmodule

// File: rtl/pt_sum_plane.sv
module pt_sum_plane #(
    parameter int N_OUT = 4,
    parameter int T_PER = 2
) (
    input  logic [N_OUT*T_PER-1:0] hits,
    output logic [N_OUT-1:0]       sel
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        assign sel[o] = |hits[o*T_PER +: T_PER];
    end
endmodule

// File: rtl/pt_addr_decoder.sv
module pt_addr_decoder
    import pt_dec_pkg::*;
#(
    parameter int AH_W   = 8,
    parameter int PG_W   = 4,
    parameter int AUX_W  = 4,
    parameter int N_BANK = 8,
    parameter int XA_N   = 4,
    parameter int XA_T   = 4,
    parameter int XB_N   = 4,
    parameter int XB_T   = 2,
    parameter int XC_N   = 3,
    parameter int XC_T   = 1,
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AH_W+PG_W+AUX_W+3:0] cfg_wdata,
    input  logic [AH_W-1:0]   addr_hi,
    input  logic              a19_csi,
    input  logic [PG_W-1:0]   page,
    input  logic              rd,
    input  logic              wr,
    input  logic              ale,
    input  logic [AUX_W-1:0]  aux,
    output logic [N_BANK-1:0] bank_sel,
    output logic              sram_sel,
    output logic              io_sel,
    output logic [XA_N-1:0]   xcs_a,
    output logic [XB_N-1:0]   xcs_b,
    output logic [XC_N-1:0]   xcs_c,
    output logic              pwr_down
);
    localparam int IN_W    = AH_W + 1 + PG_W + 3 + AUX_W;
    localparam int BANK_B  = 0;
    localparam int LOC_B   = BANK_B + N_BANK;
    localparam int XA_B    = LOC_B + 2;
    localparam int XB_B    = XA_B + XA_N * XA_T;
    localparam int XC_B    = XB_B + XB_N * XB_T;
    localparam int N_TERMS = XC_B + XC_N * XC_T;

    logic [IN_W-1:0]              in_vec;
    logic [N_TERMS-1:0][IN_W-1:0] care;
    logic [N_TERMS-1:0][IN_W-1:0] value;
    logic [N_TERMS-1:0]           valid;
    logic [N_TERMS-1:0]           hit;
    logic                         csi_mode_q;

    logic [N_BANK-1:0] bank_raw;
    logic [1:0]        loc_raw;
    logic [XA_N-1:0]   xa_raw;
    logic [XB_N-1:0]   xb_raw;
    logic [XC_N-1:0]   xc_raw;

    run_state_e st_q, st_d;
    dec_mode_e  mode;

    assign in_vec = {aux, ale, wr, rd, page, a19_csi, addr_hi};

    pt_cfg_regs #(.IN_W(IN_W), .N_TERMS(N_TERMS), .AW(CFG_AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .care     (care),
        .value    (value),
        .valid    (valid),
        .csi_mode (csi_mode_q)
    );

    pt_term_eval #(.IN_W(IN_W), .N_TERMS(N_TERMS)) u_and (
        .in_vec (in_vec),
        .care   (care),
        .value  (value),
        .valid  (valid),
        .hit    (hit)
    );

    pt_sum_plane #(.N_OUT(N_BANK), .T_PER(1)) u_or_bank (
        .hits (hit[BANK_B +: N_BANK]), .sel (bank_raw));
    pt_sum_plane #(.N_OUT(2), .T_PER(1)) u_or_loc (
        .hits (hit[LOC_B +: 2]), .sel (loc_raw));
    pt_sum_plane #(.N_OUT(XA_N), .T_PER(XA_T)) u_or_xa (
        .hits (hit[XA_B +: XA_N*XA_T]), .sel (xa_raw));
    pt_sum_plane #(.N_OUT(XB_N), .T_PER(XB_T)) u_or_xb (
        .hits (hit[XB_B +: XB_N*XB_T]), .sel (xb_raw));
    pt_sum_plane #(.N_OUT(XC_N), .T_PER(XC_T)) u_or_xc (
        .hits (hit[XC_B +: XC_N*XC_T]), .sel (xc_raw));

    // HOLD -> RUN on the first edge after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_HOLD: st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_HOLD;
        endcase
    end

    // live mode: DECODE <-> SLEEP follows the shared pin without delay
    always_comb begin
        if (!rst_n || st_q == ST_HOLD)    mode = DM_RESET;
        else if (csi_mode_q && a19_csi)   mode = DM_SLEEP;
        else                              mode = DM_DECODE;
    end

    always_comb begin
        bank_sel = '0;
        sram_sel = 1'b0;
        io_sel   = 1'b0;
        xcs_a    = '0;
        xcs_b    = '0;
        xcs_c    = '0;
        pwr_down = 1'b0;
        unique case (mode)
            DM_DECODE: begin
                bank_sel = bank_raw;
                sram_sel = loc_raw[0];
                io_sel   = loc_raw[1];
                xcs_a    = xa_raw;
                xcs_b    = xb_raw;
                xcs_c    = xc_raw;
            end
            DM_SLEEP: pwr_down = 1'b1;
            DM_RESET: pwr_down = 1'b0;
            default:  pwr_down = 1'b0;
        endcase
    end
endmodule

// File: rtl/pt_addr_decoder_chk.sv
module pt_addr_decoder_chk #(
    parameter int N_BANK = 8,
    parameter int XA_N   = 4,
    parameter int XB_N   = 4,
    parameter int XC_N   = 3,
    parameter int CFG_AW = 8,
    parameter int CTRL_A = 148
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              cfg_bit0,
    input logic              a19_csi,
    input logic              csi_mode_q,
    input logic [N_BANK-1:0] bank_sel,
    input logic              sram_sel,
    input logic              io_sel,
    input logic [XA_N-1:0]   xcs_a,
    input logic [XB_N-1:0]   xcs_b,
    input logic [XC_N-1:0]   xcs_c,
    input logic              pwr_down
);
    logic any_sel;
    assign any_sel = (|bank_sel) | sram_sel | io_sel | (|xcs_a) | (|xcs_b) | (|xcs_c);

    a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !any_sel);

    a_r6_sleep_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (a19_csi && csi_mode_q));

    a_r7_addr_mode_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !csi_mode_q |-> !pwr_down);

    a_r5_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(CTRL_A)) |=> (csi_mode_q == $past(cfg_bit0)));

    // R8: reset deselects everything
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!any_sel && !pwr_down));
endmodule

bind pt_addr_decoder pt_addr_decoder_chk #(
    .N_BANK (N_BANK), .XA_N (XA_N), .XB_N (XB_N), .XC_N (XC_N),
    .CFG_AW (CFG_AW), .CTRL_A (N_TERMS * 4)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_bit0   (cfg_wdata[0]),
    .a19_csi    (a19_csi),
    .csi_mode_q (csi_mode_q),
    .bank_sel   (bank_sel),
    .sram_sel   (sram_sel),
    .io_sel     (io_sel),
    .xcs_a      (xcs_a),
    .xcs_b      (xcs_b),
    .xcs_c      (xcs_c),
    .pwr_down   (pwr_down)
);

// File: tb/tb_pt_addr_decoder.sv
`timescale 1ns/1ps
module tb_pt_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [19:0] cfg_wdata = '0;
    logic [7:0]  addr_hi = '0;
    logic        a19_csi = 1'b0;
    logic [3:0]  page = '0;
    logic        rd = 1'b0, wr = 1'b0, ale = 1'b0;
    logic [3:0]  aux = '0;
    logic [7:0]  bank_sel;
    logic        sram_sel, io_sel, pwr_down;
    logic [3:0]  xcs_a, xcs_b;
    logic [2:0]  xcs_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pt_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .addr_hi(addr_hi), .a19_csi(a19_csi),
        .page(page), .rd(rd), .wr(wr), .ale(ale), .aux(aux),
        .bank_sel(bank_sel), .sram_sel(sram_sel), .io_sel(io_sel),
        .xcs_a(xcs_a), .xcs_b(xcs_b), .xcs_c(xcs_c), .pwr_down(pwr_down)
    );

    logic [20:0] obs;
    assign obs = {bank_sel, sram_sel, io_sel, xcs_a, xcs_b, xcs_c};

    // inputs {aux, ale, wr, rd, page, a19, addr_hi}; results {bank, sram, io, xa, xb, xc}
    localparam logic [19:0] VIN [8] = '{
        {4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00},
        {4'h0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 8'hA0},
        {4'h0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00},
        {4'h0, 1'b0, 1'b0, 1'b0, 4'hA, 1'b1, 8'hE0},
        {4'h0, 1'b0, 1'b0, 1'b0, 4'h3, 1'b1, 8'hE0},
        {4'h5, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h61},
        {4'h1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h60},
        {4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 8'hFF}
    };
    localparam logic [20:0] VEXP [8] = '{
        {8'h01, 1'b0, 1'b0, 4'h0, 4'h2, 3'h0},
        {8'h20, 1'b0, 1'b0, 4'h1, 4'h2, 3'h0},
        {8'h00, 1'b1, 1'b0, 4'h1, 4'h2, 3'h0},
        {8'h00, 1'b0, 1'b1, 4'h0, 4'h2, 3'h0},
        {8'h00, 1'b0, 1'b0, 4'h0, 4'h3, 3'h0},
        {8'h08, 1'b0, 1'b0, 4'h8, 4'h2, 3'h0},
        {8'h08, 1'b0, 1'b0, 4'h0, 4'h2, 3'h4},
        {8'h80, 1'b0, 1'b0, 4'h8, 4'h2, 3'h0}
    };

    task automatic chk(string tag, logic [20:0] got, logic [20:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic drive(logic [19:0] v);
        @(negedge clk);
        {aux, ale, wr, rd, page, a19_csi, addr_hi} = v;
        #1;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_term(int t, logic [19:0] c, logic [19:0] v, logic en);
        cfg_write(8'(t * 4), c);
        cfg_write(8'(t * 4 + 1), v);
        cfg_write(8'(t * 4 + 2), {19'b0, en});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R8 quiet in reset", {obs[20:0]}, 21'h0);
        chk("R8 no power-down in reset", {20'h0, pwr_down}, 21'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int t = 0; t < 37; t++) set_term(t, 20'h0, 20'h0, 1'b0);
        for (int i = 0; i < 8; i++) set_term(i, 20'h001E0, 20'(i << 5), 1'b1);
        set_term(8,  20'h001E0, 20'h00100, 1'b1);
        set_term(9,  20'h01FE0, 20'h015E0, 1'b1);
        set_term(10, 20'h02000, 20'h02000, 1'b1);
        set_term(11, 20'h04000, 20'h04000, 1'b1);
        set_term(22, 20'hF0000, 20'h50000, 1'b1);
        set_term(23, 20'h08000, 20'h08000, 1'b1);
        set_term(26, 20'h01E00, 20'h00600, 1'b1);
        set_term(28, 20'h00000, 20'h00000, 1'b1);
        set_term(36, 20'h10001, 20'h10000, 1'b1);

        // R1, R2, R3: decode table
        for (int i = 0; i < 8; i++) begin
            drive(VIN[i]);
            chk($sformatf("R1/R3 vector %0d", i), obs, VEXP[i]);
        end

        // R4: field 3 and addresses past the control register change nothing
        cfg_write(8'h03, 20'hFFFFF);
        cfg_write(8'hFF, 20'hFFFFF);
        cfg_write(8'h6F, 20'hFFFFF);
        drive(VIN[0]);
        chk("R4 unmapped writes ignored v0", obs, VEXP[0]);
        drive(VIN[1]);
        chk("R4 unmapped writes ignored v1", obs, VEXP[1]);

        // R5, R6: chip-select-input mode
        cfg_write(8'h94, 20'h1);
        drive(VIN[0] | 20'h00100);
        chk("R6 sleep deselects", obs, 21'h0);
        chk("R6 sleep flag", {20'h0, pwr_down}, 21'h1);
        drive(VIN[3]);
        chk("R6 sleep over always-true term", obs, 21'h0);
        drive(VIN[0]);
        chk("R6 pin low decodes", obs, VEXP[0]);
        chk("R6 pin low flag", {20'h0, pwr_down}, 21'h0);

        // R7: address mode
        cfg_write(8'h94, 20'h0);
        drive(VIN[2]);
        chk("R7 pin is a literal", obs, VEXP[2]);
        chk("R7 no power-down", {20'h0, pwr_down}, 21'h0);

        // R2: disabling the always-true slot
        cfg_write(8'(28 * 4 + 2), 20'h0);
        drive(VIN[0]);
        chk("R2 disabled slot false", obs, {8'h01, 1'b0, 1'b0, 4'h0, 4'h0, 3'h0});

        // R8 mid-run reset, with writes dropped during reset (R4, R5)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 reset deselects live", obs, 21'h0);
        cfg_write(8'(28 * 4 + 2), 20'h1);
        cfg_write(8'h94, 20'h1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 hold until first edge", obs, 21'h0);
        @(posedge clk);
        #1;
        chk("R4 term write in reset dropped", obs, {8'h01, 1'b0, 1'b0, 4'h0, 4'h0, 3'h0});
        drive(VIN[2] | 20'h00100);
        chk("R5 mode write in reset dropped", obs, {8'h00, 1'b1, 1'b0, 4'h1, 4'h0, 3'h0});
        chk("R5 mode write in reset flag", {20'h0, pwr_down}, 21'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule